// File: doc/BRIEF.md
# Rotate-and-Mask Word Unit

This block rotates a data word left and then keeps only the bits selected by a contiguous mask. The mask is described by a begin index and an end index. Bit numbering is big-endian: index 0 is the most significant bit, which is port bit W-1. If the begin index is larger than the end index, the mask wraps around the word. The rotated and masked bits can replace the whole result, or they can be merged into an old destination word so that the destination keeps its bits outside the mask.

The rotate amount comes from one of two places. It is either an immediate field or the low bits of a register operand, selected by a 2-bit mode input. When the record flag is set, a condition nibble compares the result with zero as a signed number and carries a summary-overflow bit through. The OUT_REG parameter chooses between two variants: a purely combinational unit, or the same logic followed by one register stage.

Top module: `rmw_unit`

## Requirements
- R1: When mask_b <= mask_e, the mask has big-endian index i set for every i from mask_b to mask_e inclusive. Big-endian index i is port bit W-1-i. All other bits are clear.
- R2: When mask_b > mask_e, the mask is set at indices 0..mask_e and at indices mask_b..W-1, and clear everywhere between.
- R3: Mode 2'b00 gives rotl(src_word, sh_imm) AND mask.
- R4: Mode 2'b01 gives (dst_word AND NOT mask) OR (rotl(src_word, sh_imm) AND mask).
- R5: Mode 2'b10 gives rotl(src_word, sh_reg) AND mask. In this mode sh_imm has no effect. In every other mode sh_reg has no effect.
- R6: Mode 2'b11 behaves exactly like mode 2'b00.
- R7: A rotate amount of 0 with a full mask (mask_b = 0, mask_e = W-1) returns src_word unchanged.
- R8: When rec_en is 1, cond_nib holds the following bits: [3] result < 0 (signed), [2] result > 0, [1] result == 0, and [0] a copy of so_in.
- R9: When rec_en is 0, cond_nib is 4'b0000.
- R10: With OUT_REG = 1, res_word and cond_nib show the value for the inputs present one rising clock edge earlier. While rst_n is low, both outputs are 0.
- R11: With OUT_REG = 0, res_word and cond_nib follow the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 plain, 01 insert, 10 register amount, 11 same as plain |
| src_word | input | W | Word to rotate |
| dst_word | input | W | Old destination word used by insert mode |
| sh_imm | input | log2(W) | Immediate rotate amount |
| sh_reg | input | log2(W) | Rotate amount taken from the register operand |
| mask_b | input | log2(W) | Mask begin index (big-endian) |
| mask_e | input | log2(W) | Mask end index (big-endian) |
| rec_en | input | 1 | Record flag; enables the condition nibble |
| so_in | input | 1 | Summary-overflow bit copied into the nibble |
| res_word | output | W | Result word |
| cond_nib | output | 4 | {lt, gt, eq, so} |

## Verification
The bench builds the unit twice at the default word width of 32. One copy has OUT_REG = 1 and the other has OUT_REG = 0, so the latency of the registered copy and the immediate response of the combinational copy are both compared against the same expected values.

At this width, all 1024 begin/end pairs can be swept in full. The sweep covers every wrapped mask, every single-bit mask and the full mask. A second full sweep steps through all four modes, varied rotate amounts, both amount sources and both settings of the record flag, with garbage on the amount source that is not selected.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
   typedef enum logic [1:0] {
      RMW_PLAIN  = 2'b00,
      RMW_INSERT = 2'b01,
      RMW_BYREG  = 2'b10,
      RMW_ALT    = 2'b11
   } rmw_mode_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } rmw_cond_t;
endpackage

// File: rtl/rmw_mask_gen.sv
module rmw_mask_gen #(
   parameter int W   = 32,
   parameter int SHW = 5
) (
   input  logic [SHW-1:0] beg_idx,
   input  logic [SHW-1:0] end_idx,
   output logic [W-1:0]   mask
);
   localparam logic [W-1:0] ONES = '1;

   logic [SHW:0]   end_next;
   logic [W-1:0]   from_beg;
   logic [W-1:0]   upto_end;

   // Big-endian index i sits at port bit W-1-i.
   assign end_next = {1'b0, end_idx} + 1'b1;
   assign from_beg = ONES >> beg_idx;
   assign upto_end = ~(ONES >> end_next);

   always_comb begin
      if (beg_idx <= end_idx) mask = from_beg & upto_end;
      else                    mask = from_beg | upto_end;
   end
endmodule

// File: rtl/rmw_rotl.sv
module rmw_rotl #(
   parameter int W   = 32,
   parameter int SHW = 5
) (
   input  logic [W-1:0]   din,
   input  logic [SHW-1:0] amt,
   output logic [W-1:0]   dout
);
   logic [W-1:0] stg [0:SHW];

   assign stg[0] = din;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stg[k+1] = amt[k] ? ((stg[k] << D) | (stg[k] >> (W - D))) : stg[k];
   end

   assign dout = stg[SHW];
endmodule

// File: rtl/rmw_cond.sv
module rmw_cond #(
   parameter int W = 32
) (
   input  logic [W-1:0] val,
   input  logic         en,
   input  logic         so,
   output logic [3:0]   nib
);
   import rmw_pkg::*;

   rmw_cond_t c;

   always_comb begin
      c.lt = val[W-1];
      c.eq = (val == '0);
      c.gt = !val[W-1] && (val != '0);
      c.so = so;
      nib  = en ? c : 4'b0000;
   end
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit #(
   parameter int W       = 32,
   parameter int OUT_REG = 1,
   localparam int SHW    = $clog2(W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     mode,
   input  logic [W-1:0]   src_word,
   input  logic [W-1:0]   dst_word,
   input  logic [SHW-1:0] sh_imm,
   input  logic [SHW-1:0] sh_reg,
   input  logic [SHW-1:0] mask_b,
   input  logic [SHW-1:0] mask_e,
   input  logic           rec_en,
   input  logic           so_in,
   output logic [W-1:0]   res_word,
   output logic [3:0]     cond_nib
);
   import rmw_pkg::*;

   if (W < 4 || (1 << SHW) != W) begin : g_bad_width
      $error("rmw_unit: W must be a power of two of at least 4");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("rmw_unit: OUT_REG must be 0 or 1");
   end

   rmw_mode_e      mode_e;
   logic [SHW-1:0] amt;
   logic [W-1:0]   rot_w;
   logic [W-1:0]   mask_w;
   logic [W-1:0]   res_c;
   logic [3:0]     cond_c;

   assign mode_e = rmw_mode_e'(mode);
   assign amt    = (mode_e == RMW_BYREG) ? sh_reg : sh_imm;

   rmw_rotl #(.W(W), .SHW(SHW)) u_rotl (
      .din  (src_word),
      .amt  (amt),
      .dout (rot_w)
   );

   rmw_mask_gen #(.W(W), .SHW(SHW)) u_mask (
      .beg_idx (mask_b),
      .end_idx (mask_e),
      .mask    (mask_w)
   );

   always_comb begin
      if (mode_e == RMW_INSERT) res_c = (dst_word & ~mask_w) | (rot_w & mask_w);
      else                      res_c = rot_w & mask_w;
   end

   rmw_cond #(.W(W)) u_cond (
      .val (res_c),
      .en  (rec_en),
      .so  (so_in),
      .nib (cond_c)
   );

   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_word <= '0;
            cond_nib <= '0;
         end else begin
            res_word <= res_c;
            cond_nib <= cond_c;
         end
      end
   end else begin : g_comb
      assign res_word = res_c;
      assign cond_nib = cond_c;
   end
endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk #(
   parameter int W       = 32,
   parameter int OUT_REG = 1,
   localparam int SHW    = $clog2(W)
) (
   input logic           clk,
   input logic           rst_n,
   input logic [1:0]     mode,
   input logic [W-1:0]   src_word,
   input logic [W-1:0]   dst_word,
   input logic [SHW-1:0] sh_imm,
   input logic [SHW-1:0] mask_b,
   input logic [SHW-1:0] mask_e,
   input logic           rec_en,
   input logic [W-1:0]   mask_w,
   input logic [W-1:0]   res_c,
   input logic [3:0]     cond_c,
   input logic [W-1:0]   res_word
);
   // R1: equal begin and end select exactly one bit
   a_r1_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_b == mask_e) |-> ($countones(mask_w) == 1));

   // R3: plain mode leaves every bit outside the mask clear
   a_r3_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> ((res_c & ~mask_w) == '0));

   // R4: insert mode keeps destination bits outside the mask
   a_r4_keep_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> ((res_c & ~mask_w) == (dst_word & ~mask_w)));

   // R7: zero rotate with full mask is identity
   a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && sh_imm == '0 && mask_b == '0 && mask_e == SHW'(W-1))
         |-> (res_c == src_word));

   // R8: exactly one of lt/gt/eq when recording
   a_r8_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |-> ($countones(cond_c[3:1]) == 1));

   // R9: nibble is clear without the record flag
   a_r9_no_record: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_en |-> (cond_c == 4'b0000));

   if (OUT_REG != 0) begin : g_lat
      // R10: registered output lags the combinational value by one edge
      a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (res_word == $past(res_c)));
   end
endmodule

bind rmw_unit rmw_unit_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .src_word (src_word),
   .dst_word (dst_word),
   .sh_imm   (sh_imm),
   .mask_b   (mask_b),
   .mask_e   (mask_e),
   .rec_en   (rec_en),
   .mask_w   (mask_w),
   .res_c    (res_c),
   .cond_c   (cond_c),
   .res_word (res_word)
);

// File: tb/test_rmw_unit.sv
`timescale 1ns/1ps
module test_rmw_unit;
   localparam int W = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode;
   logic [31:0] src, dst;
   logic [4:0]  shi, shr, mb, me;
   logic        rec_en, so_in;
   logic [31:0] res_r, res_c;
   logic [3:0]  cond_r, cond_c;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rmw_unit #(.W(W), .OUT_REG(1)) i_rmw_unit (
      .clk(clk), .rst_n(rst_n), .mode(mode), .src_word(src), .dst_word(dst),
      .sh_imm(shi), .sh_reg(shr), .mask_b(mb), .mask_e(me),
      .rec_en(rec_en), .so_in(so_in), .res_word(res_r), .cond_nib(cond_r));

   rmw_unit #(.W(W), .OUT_REG(0)) i_rmw_unit_comb (
      .clk(clk), .rst_n(rst_n), .mode(mode), .src_word(src), .dst_word(dst),
      .sh_imm(shi), .sh_reg(shr), .mask_b(mb), .mask_e(me),
      .rec_en(rec_en), .so_in(so_in), .res_word(res_c), .cond_nib(cond_c));

   task automatic chk(input string tag, input string path,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] act=%h exp=%h", tag, path, act, exp);
      end
   endtask

   function automatic logic [31:0] f_mask(input int b, input int e);
      logic [31:0] m = '0;
      for (int i = 0; i < 32; i++) begin
         if ((b <= e) ? (i >= b && i <= e) : (i <= e || i >= b)) m[31-i] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [31:0] f_rotl(input logic [31:0] x, input int s);
      logic [63:0] t = {x, x} << s;
      return t[63:32];
   endfunction

   function automatic logic [3:0] f_cond(input logic [31:0] v, input logic en, input logic so);
      int sv = $signed(v);
      if (!en) return 4'b0000;
      return {sv < 0, sv > 0, sv == 0, so};
   endfunction

   bit          prev_ok = 1'b0;
   logic [31:0] prev_res;
   logic [3:0]  prev_cond;
   string       prev_tag, prev_ctag;

   task automatic apply(input logic [1:0] m, input logic [31:0] s, input logic [31:0] d,
                        input logic [4:0] si, input logic [4:0] sr, input int b, input int e,
                        input logic re, input logic so, input string tag);
      logic [31:0] r, mk, ex;
      logic [3:0]  ec;
      string       ctag;
      @(negedge clk);
      if (prev_ok) begin
         chk(prev_tag, "R10 registered", res_r, prev_res);
         chk(prev_ctag, "R10 registered", {28'd0, cond_r}, {28'd0, prev_cond});
      end
      mode = m; src = s; dst = d; shi = si; shr = sr;
      mb = 5'(b); me = 5'(e); rec_en = re; so_in = so;
      r  = f_rotl(s, (m == 2'b10) ? int'(sr) : int'(si));
      mk = f_mask(b, e);
      ex = (m == 2'b01) ? ((d & ~mk) | (r & mk)) : (r & mk);
      ec = f_cond(ex, re, so);
      ctag = re ? "R8" : "R9";
      #1;
      chk(tag, "R11 combinational", res_c, ex);
      chk(ctag, "R11 combinational", {28'd0, cond_c}, {28'd0, ec});
      prev_ok = 1'b1; prev_res = ex; prev_cond = ec; prev_tag = tag; prev_ctag = ctag;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) act=timeout exp=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      mode = 2'b00; src = 32'hDEADBEEF; dst = 32'h12345678;
      shi = 5'd3; shr = 5'd7; mb = 5'd0; me = 5'd31; rec_en = 1'b1; so_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "reset value", res_r, 32'h0);
      chk("R10", "reset value", {28'd0, cond_r}, 32'h0);
      rst_n = 1'b1;

      // Mask shape over every begin/end pair (R1 plain ranges, R2 wrapped)
      for (int b = 0; b < 32; b++) begin
         for (int e = 0; e < 32; e++) begin
            apply(2'b00, 32'hFFFF_FFFF, 32'h0, 5'd0, 5'd17, b, e, 1'b0, 1'b1,
                  (b <= e) ? "R1" : "R2");
         end
      end

      // All modes, varied amounts, garbage on the unused amount source
      for (int b = 0; b < 32; b++) begin
         for (int e = 0; e < 32; e++) begin
            logic [1:0]  m  = 2'((b + e) & 3);
            logic [4:0]  sh = 5'((b * 7 + e * 3) & 31);
            logic [31:0] s  = 32'hC6A4_A793 * (b * 32 + e + 1);
            logic [31:0] d  = ~s ^ 32'h0F0F_1234;
            string       tg;
            case (m)
               2'b00:   tg = "R3";
               2'b01:   tg = "R4";
               2'b10:   tg = "R5";
               default: tg = "R6";
            endcase
            if (m == 2'b10) apply(m, s, d, ~sh, sh, b, e, 1'(b ^ e), 1'(b >> 1), tg);
            else            apply(m, s, d, sh, ~sh, b, e, 1'(b ^ e), 1'(b >> 1), tg);
         end
      end

      // Zero rotate with full mask returns the source
      apply(2'b00, 32'h8000_0001, 32'h0, 5'd0, 5'd9, 0, 31, 1'b1, 1'b0, "R7");
      apply(2'b00, 32'h7FFF_FFFF, 32'h0, 5'd0, 5'd9, 0, 31, 1'b1, 1'b1, "R7");
      apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, 5'd9, 5'd0, 0, 31, 1'b1, 1'b0, "R7");
      apply(2'b01, 32'hA5A5_5A5A, 32'h1111_1111, 5'd0, 5'd3, 0, 31, 1'b0, 1'b0, "R7");

      @(negedge clk);
      chk(prev_tag, "R10 registered", res_r, prev_res);
      chk(prev_ctag, "R10 registered", {28'd0, cond_r}, {28'd0, prev_cond});

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule